// File: doc/BRIEF.md
# Multi-Format Serial PCM Receiver

This block turns a two-channel serial PCM stream into parallel 24-bit sample pairs. The stream arrives on three wires: a bit clock, a frame clock whose level marks the channel, and a data line. All three are sampled by the block's system clock, which must be fast enough for each bit-clock phase, high and low, to last at least two system-clock cycles. A two-bit format input chooses one of four framings. Three are right-justified, carrying 16, 18 or 24 bits. The fourth is a 24-bit framing that follows the common I2S convention.

In the right-justified framings, the word sits at the end of each frame-clock half-period, and whatever comes before it is ignored. In the I2S framing, the word starts one bit clock after the frame-clock transition. Shorter words come out left-aligned in the 24-bit result, so the sign stays in bit 23. A short word can also be sent in the 24-bit right-justified framing, with its unused low bits set to zero.

The output is a push stream and has no back-pressure. `out_valid` is high for exactly one system clock per frame, and the consumer must take `out_left` and `out_right` in that cycle. The sample registers then keep the pair until the next strobe.

Top module: `pcm_serial_rx`

## Requirements
- R1: `fmt_sel` encodes the framing as 00 = 16-bit right-justified, 01 = 18-bit right-justified, 10 = 24-bit right-justified, 11 = 24-bit I2S. Data is two's complement, sent MSB first, and sampled on the rising bit-clock edge.
- R2: In the right-justified framings, the word is the last N bit-clock periods before a frame-clock transition, with its LSB in the final period. Earlier bits of the half-period have no effect. Frame clock high marks the left channel.
- R3: 16-bit and 18-bit words appear in bits 23 and down of the output, with zeros below them. In the 24-bit right-justified framing all 24 bits pass through unchanged.
- R4: In the I2S framing, frame clock low marks the left channel. The MSB is in the second bit-clock period after the transition and the following 23 periods carry the rest of the word. If the half-period is shorter than 25 periods, the missing low bits read as zero. Bits after the 24th have no effect.
- R5: Decoding is correct at the minimum bit-clock rates of 32fs (16-bit right-justified and I2S), 36fs (18-bit) and 48fs (24-bit right-justified), and at higher rates up to 64fs.
- R6: `out_valid` is high for one system clock once per frame. It rises a few system clocks after the frame-clock transition that ends the right channel, and only when a left word has been captured earlier in the same frame.
- R7: `out_left` and `out_right` change only in a cycle where `out_valid` is high, and keep their values between strobes.
- R8: `fmt_sel` takes effect only at a frame boundary or at the first frame-clock transition after reset. A change that is undone before the boundary does not affect the frame in progress.
- R9: During reset, `out_valid` and both samples are zero and the format is I2S. The half-period that is running when the first frame-clock transition is seen produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing select (see R1) |
| bck_in | input | 1 | Serial bit clock, asynchronous to clk |
| lrck_in | input | 1 | Frame clock (channel select), asynchronous to clk |
| sdata_in | input | 1 | Serial data |
| out_valid | output | 1 | One-cycle strobe for a complete sample pair |
| out_left | output | 24 | Left-channel sample, left-aligned two's complement |
| out_right | output | 24 | Right-channel sample, left-aligned two's complement |

## Verification
The bound checker enforces four rules on every cycle:
- the strobe is never wider than one cycle;
- the sample registers change only together with the strobe;
- the latched format changes only on a detected frame-clock transition;
- every pair delivered in the 16-bit or 18-bit framing has its low bits cleared.

The bench covers the behaviours that depend on bit order and timing in the serial stream. It sweeps every framing across its minimum and higher bit-clock rates, with full-scale positive, full-scale negative, all-ones, zero and mixed words. It places non-zero filler bits in every don't-care position and makes a temporary format change inside a frame. It also checks that the partial half-period after reset yields no pair.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int RJ16_W   = 16;
  localparam int RJ18_W   = 18;

  typedef enum logic [1:0] {
    FMT_RJ16  = 2'b00,
    FMT_RJ18  = 2'b01,
    FMT_RJ24  = 2'b10,
    FMT_I2S24 = 2'b11
  } pcm_fmt_e;
endpackage

// File: rtl/pcm_rx_front.sv
// Synchronises the three serial lines into the system clock and derives
// a bit strobe (rising bit clock) and a frame-clock transition flag.
module pcm_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_in,
  input  logic lrck_in,
  input  logic sd_in,
  output logic bit_stb,
  output logic bit_val,
  output logic lr_edge,
  output logic lr_prev
);
  localparam int LANES = 3;
  localparam int LAST  = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][LANES-1:0] sync_q;
  logic bck_s, lr_s, sd_s;
  logic bck_d, primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= {bck_in, lrck_in, sd_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign bck_s = sync_q[LAST][2];
  assign lr_s  = sync_q[LAST][1];
  assign sd_s  = sync_q[LAST][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_d   <= 1'b0;
      lr_prev <= 1'b0;
      primed  <= 1'b0;
    end else begin
      bck_d <= bck_s;
      if (bit_stb) begin
        lr_prev <= lr_s;
        primed  <= 1'b1;
      end
    end
  end

  assign bit_stb = bck_s & ~bck_d;
  assign bit_val = sd_s;
  assign lr_edge = bit_stb & primed & (lr_s ^ lr_prev);
endmodule

// File: rtl/pcm_rx_word.sv
// Collects the bits of one half-period. A free-running shifter serves the
// right-justified framings; a position counter serves the I2S framing.
module pcm_rx_word
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic                lr_edge,
  input  pcm_fmt_e            fmt,
  output logic [SAMPLE_W-1:0] word
);
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] i2s_acc;
  logic [CNT_W-1:0]    pos_cnt;
  logic [IDX_W-1:0]    wr_idx;
  logic                in_word;

  assign in_word = (pos_cnt != '0) && (pos_cnt <= CNT_LAST);
  assign wr_idx  = IDX_W'(SAMPLE_W - int'(pos_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      i2s_acc <= '0;
      pos_cnt <= '0;
    end else if (bit_stb) begin
      shreg <= {shreg[SAMPLE_W-2:0], bit_val};
      if (lr_edge) begin
        i2s_acc <= '0;
        pos_cnt <= CNT_W'(1);
      end else begin
        if (in_word) i2s_acc[wr_idx] <= bit_val;
        if (pos_cnt != CNT_TOP) pos_cnt <= pos_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (fmt)
      FMT_RJ16: word = {shreg[RJ16_W-1:0], {(SAMPLE_W-RJ16_W){1'b0}}};
      FMT_RJ18: word = {shreg[RJ18_W-1:0], {(SAMPLE_W-RJ18_W){1'b0}}};
      FMT_RJ24: word = shreg;
      default:  word = i2s_acc;
    endcase
  end
endmodule

// File: rtl/pcm_rx_frame.sv
// Pairs left and right words into a frame and latches the format at
// frame boundaries.
module pcm_rx_frame
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lr_edge,
  input  logic                lr_prev,
  input  logic [SAMPLE_W-1:0] word,
  input  pcm_fmt_e            fmt_sel,
  output pcm_fmt_e            fmt_q,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  logic                armed, have_l, left_done;
  logic [SAMPLE_W-1:0] word_l;

  assign left_done = (fmt_q == FMT_I2S24) ? ~lr_prev : lr_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      have_l    <= 1'b0;
      word_l    <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
      fmt_q     <= FMT_I2S24;
    end else begin
      out_valid <= 1'b0;
      if (lr_edge) begin
        if (!armed) begin
          armed <= 1'b1;
          fmt_q <= fmt_sel;
        end else if (left_done) begin
          word_l <= word;
          have_l <= 1'b1;
        end else begin
          fmt_q  <= fmt_sel;
          have_l <= 1'b0;
          if (have_l) begin
            out_left  <= word_l;
            out_right <= word;
            out_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                bck_in,
  input  logic                lrck_in,
  input  logic                sdata_in,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  logic                bit_stb, bit_val, lr_edge, lr_prev;
  logic [SAMPLE_W-1:0] word;
  pcm_fmt_e            fmt_q;

  pcm_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .bck_in(bck_in), .lrck_in(lrck_in), .sd_in(sdata_in),
    .bit_stb(bit_stb), .bit_val(bit_val),
    .lr_edge(lr_edge), .lr_prev(lr_prev)
  );

  pcm_rx_word #(.CNT_W(CNT_W)) u_word (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .bit_val(bit_val), .lr_edge(lr_edge),
    .fmt(fmt_q), .word(word)
  );

  pcm_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .lr_edge(lr_edge), .lr_prev(lr_prev), .word(word),
    .fmt_sel(pcm_fmt_e'(fmt_sel)), .fmt_q(fmt_q),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );
endmodule

// File: rtl/pcm_rx_checker.sv
module pcm_rx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic [23:0] out_left,
  input logic [23:0] out_right,
  input logic [1:0]  fmt_q,
  input logic        lr_edge
);
  // R6: strobe lasts one system clock
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: samples hold between strobes
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));

  // R8: format register moves only on a frame-clock transition
  a_r8_fmt_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_q) |-> $past(lr_edge));

  // R3: 16-bit words leave the low byte clear
  a_r3_rj16_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_q) == 2'b00) |-> (out_left[7:0] == 8'h0 && out_right[7:0] == 8'h0));

  // R3: 18-bit words leave the low six bits clear
  a_r3_rj18_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt_q) == 2'b01) |-> (out_left[5:0] == 6'h0 && out_right[5:0] == 6'h0));
endmodule

bind pcm_serial_rx pcm_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right),
  .fmt_q(fmt_q), .lr_edge(lr_edge)
);

// File: tb/pcm_serial_rx_test.sv
`timescale 1ns/1ps
module pcm_serial_rx_test;
  localparam int NFR  = 6;
  localparam int NCFG = 11;
  localparam int BH   = 80;  // half bit-clock period, 4 system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b11;
  logic        bck_in = 1'b0, lrck_in = 1'b0, sdata_in = 1'b0;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int tests_run = 0, tests_failed = 0;
  int rx_cnt = 0;
  bit finished = 0;
  logic prev_valid = 1'b0;
  logic [23:0] exp_l [NFR];
  logic [23:0] exp_r [NFR];
  string cur_req = "R1";

  int cfg_fmt [NCFG] = '{0, 0, 0, 1, 1, 1, 2, 2, 3, 3, 3};
  int cfg_h   [NCFG] = '{16, 24, 32, 18, 24, 32, 24, 32, 16, 24, 32};

  always #10 clk = ~clk;

  pcm_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .bck_in(bck_in), .lrck_in(lrck_in), .sdata_in(sdata_in),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      rx_cnt = 0;
      prev_valid = 1'b0;
    end else begin
      if (prev_valid && out_valid)
        check(0, "R6 strobe wider than one cycle", 24'd1, 24'd0);
      if (out_valid) begin
        if (rx_cnt < NFR) begin
          check(out_left == exp_l[rx_cnt], {cur_req, " left"}, out_left, exp_l[rx_cnt]);
          check(out_right == exp_r[rx_cnt], {cur_req, " right"}, out_right, exp_r[rx_cnt]);
        end
        rx_cnt++;
      end
      prev_valid = out_valid;
    end
  end

  function automatic logic [23:0] gen_word(int f, int ch, int cfg, int n);
    logic [23:0] mask;
    mask = 24'((1 << n) - 1);
    if (f == 0) return (ch == 0) ? (mask >> 1) : 24'(1 << (n - 1));
    if (f == 1) return (ch == 0) ? mask : 24'h0;
    return 24'(f * 40503 + ch * 9973 + cfg * 613) & mask;
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    lrck_in = lr; sdata_in = d; bck_in = 1'b0;
    #(BH);
    bck_in = 1'b1;
    #(BH);
  endtask

  // i2s: word placed after the first bit; otherwise at the end of the half
  task automatic send_half(input logic lr, input logic [23:0] w, input int n,
                           input int h, input bit i2s, input bit poke, input logic [1:0] alt);
    logic [1:0] keep;
    keep = fmt_sel;
    for (int b = 0; b < h; b++) begin
      logic d;
      if (i2s) d = (b == 0 || b > 24) ? 1'b1 : w[24 - b];
      else     d = (b < h - n) ? ((b % 3) == 0) : w[n - 1 - (b - (h - n))];
      send_bit(lr, d);
      if (poke && b == 1) fmt_sel = alt;
    end
    fmt_sel = keep;
  endtask

  task automatic run_cfg(input int cfg);
    int fmt, h, n, kept;
    bit i2s;
    logic lvl_left;
    logic [23:0] wl [NFR];
    logic [23:0] wr [NFR];
    fmt = cfg_fmt[cfg];
    h   = cfg_h[cfg];
    i2s = (fmt == 3);
    n   = (fmt == 0) ? 16 : (fmt == 1) ? 18 : 24;
    kept = (i2s && h - 1 < 24) ? h - 1 : 24;
    lvl_left = i2s ? 1'b0 : 1'b1;
    case (fmt)
      0: cur_req = "R1 R2 R3 R5 rj16";
      1: cur_req = "R1 R2 R3 R5 rj18";
      2: cur_req = "R1 R2 R3 R5 rj24";
      default: cur_req = "R1 R4 R5 i2s";
    endcase
    for (int f = 0; f < NFR; f++) begin
      wl[f] = gen_word(f, 0, cfg, n);
      wr[f] = gen_word(f, 1, cfg, n);
      if (i2s) begin
        exp_l[f] = wl[f] & (24'hFFFFFF << (24 - kept));
        exp_r[f] = wr[f] & (24'hFFFFFF << (24 - kept));
      end else begin
        exp_l[f] = wl[f] << (24 - n);
        exp_r[f] = wr[f] << (24 - n);
      end
    end
    // reset with the format applied
    @(posedge clk); #3;
    rst_n = 1'b0; fmt_sel = 2'(fmt); lrck_in = ~lvl_left; bck_in = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    check(out_valid == 1'b0, "R9 reset valid", {23'd0, out_valid}, 24'd0);
    check(out_left == 24'd0 && out_right == 24'd0, "R9 reset samples", out_left, 24'd0);
    rst_n = 1'b1;
    // partial half before the first transition: must yield nothing
    send_half(~lvl_left, 24'hFFFFFF, n, h, i2s, 0, 2'b00);
    for (int f = 0; f < NFR; f++) begin
      send_half(lvl_left, wl[f], n, h, i2s, (f == 1), 2'(fmt) ^ 2'b01);
      send_half(~lvl_left, wr[f], n, h, i2s, 0, 2'b00);
    end
    send_half(lvl_left, 24'h0, n, h, i2s, 0, 2'b00);
    repeat (12) @(posedge clk);
    #3;
    check(rx_cnt == NFR, "R6 R9 R8 pairs per run", 24'(rx_cnt), 24'(NFR));
    check(out_left == exp_l[NFR-1] && out_right == exp_r[NFR-1], "R7 hold after last pair",
          out_left, exp_l[NFR-1]);
  endtask

  initial begin
    for (int c = 0; c < NCFG; c++) run_cfg(c);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule